// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block records which cache lines one hardware thread touches during a transaction. It keeps a separate mark for lines that were read and for lines that were written. The core side opens a transaction, reports each load or store address, and finally commits. A snoop port takes accesses made by other threads. Each snoop is checked against the lines this thread tracks, and a collision aborts the transaction.

Lines are held in a small private set-associative tag array. A tracked line stays pinned in its way until the transaction ends. If a new line maps to a set whose ways are all taken, the transaction aborts for lack of capacity, even when other sets still have room. Each hardware thread gets its own instance of the block, so one thread's transactions never use up another thread's space.

The abort cause is held on a 2-bit output until the next begin. While no transaction is open, accesses are ignored.

Top module: `txn_rwset_tracker`

## Requirements
- R1: Out of reset, `tx_active` is 0 and `abort_cause` is 0. A pulse on `tx_begin` sets `tx_active` to 1 and `abort_cause` to 0 (none) on the following cycle, and it empties the tracked set.
- R2: Tracking is per 128-byte line. Address bits [6:0] are ignored, and any number of accesses to the same line take up a single entry.
- R3: The set index is address bits [8:7] and the tag is bits [31:9]. A line may go into any free way of its set. Each of the 4 sets holds up to 16 distinct lines, for 64 in total, and filling one set does not reduce the room in another.
- R4: An access to a new line whose set already holds 16 lines causes a capacity abort. On the next cycle `abort_cause` is 1 and `tx_active` is 0.
- R5: Reads and writes draw on the same entries. A store to a line already tracked as read only marks that entry as written and uses no new way.
- R6: A snoop write to a tracked line, whether that line was read or written, causes a conflict abort. On the next cycle `abort_cause` is 2 and `tx_active` is 0.
- R7: A snoop read conflicts only with a line that has been written. A snoop read to a line that was only read causes no conflict.
- R8: `snp_conflict` is combinational. It is high in the same cycle as a colliding snoop while a transaction is open.
- R9: A commit while active ends the transaction with `abort_cause` 0 and frees every way. A following transaction again has the full 16 ways in each set.
- R10: After an abort or a commit, accesses and snoops have no effect and `abort_cause` holds its value until the next begin.
- R11: Priority in one cycle runs begin, then commit, then conflict, then the access. A colliding snoop in the same cycle as an overflowing access reports conflict. A commit in the same cycle as a colliding snoop ends cleanly.
- R12: A snoop to a line that is not tracked, including a different tag in the same set, causes no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_begin | input | 1 | Open a new transaction |
| tx_commit | input | 1 | Commit the open transaction |
| acc_valid | input | 1 | Local access present |
| acc_write | input | 1 | Local access is a store (1) or a load (0) |
| acc_addr | input | ADDR_W | Local byte address |
| snp_valid | input | 1 | Remote access present |
| snp_write | input | 1 | Remote access is a write (1) or a read (0) |
| snp_addr | input | ADDR_W | Remote byte address |
| tx_active | output | 1 | A transaction is open |
| abort_cause | output | 2 | 0 none, 1 capacity, 2 conflict |
| snp_conflict | output | 1 | Current snoop collides with the tracked set |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 128-byte lines, 4 sets and 16 ways. With these values a few dozen accesses are enough to fill a set to exactly 16 lines and to push it one line past the limit. Random tags are drawn from a pool of 20 per set, so the random phase keeps reaching capacity aborts, re-hits of tracked lines and read/write promotions. Directed cases cover same-cycle priority, commit and refill, and snoops against lines that were only read versus lines that were written.

// File: rtl/txn_rwset_tracker.sv
module txn_rwset_tracker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 7,
  parameter int SETS      = 4,
  parameter int WAYS      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              tx_active,
  output logic [1:0]        abort_cause,
  output logic              snp_conflict
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - LINE_BITS - SET_W;
  localparam logic [1:0] CAUSE_NONE = 2'd0;
  localparam logic [1:0] CAUSE_CAP  = 2'd1;
  localparam logic [1:0] CAUSE_CONF = 2'd2;

  logic [WAYS-1:0]  vld [SETS];
  logic [WAYS-1:0]  rdb [SETS];
  logic [WAYS-1:0]  wrb [SETS];
  logic [TAG_W-1:0] tags [SETS][WAYS];

  logic [SET_W-1:0] a_set, s_set;
  logic [TAG_W-1:0] a_tag, s_tag;
  assign a_set = acc_addr[LINE_BITS +: SET_W];
  assign s_set = snp_addr[LINE_BITS +: SET_W];
  assign a_tag = acc_addr[ADDR_W-1 -: TAG_W];
  assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] a_hit, a_free, s_coll;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign a_hit[w]  = vld[a_set][w] && (tags[a_set][w] == a_tag);
    assign a_free[w] = !vld[a_set][w];
    assign s_coll[w] = vld[s_set][w] && (tags[s_set][w] == s_tag) &&
                       (snp_write ? (rdb[s_set][w] || wrb[s_set][w]) : wrb[s_set][w]);
  end

  logic [WAY_W-1:0] hit_way, alloc_way;
  always_comb begin
    hit_way   = '0;
    alloc_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (a_hit[w])  hit_way   = WAY_W'(w);
      if (a_free[w]) alloc_way = WAY_W'(w);
    end
  end

  assign snp_conflict = snp_valid && tx_active && (|s_coll);

  logic idle_cycle, go_conflict, go_acc, go_hit, go_alloc, go_cap, clear_all;
  assign idle_cycle  = tx_active && !tx_begin && !tx_commit;
  assign go_conflict = idle_cycle && snp_conflict;
  assign go_acc      = idle_cycle && !snp_conflict && acc_valid;
  assign go_hit      = go_acc && (|a_hit);
  assign go_alloc    = go_acc && !(|a_hit) && (|a_free);
  assign go_cap      = go_acc && !(|a_hit) && !(|a_free);
  assign clear_all   = tx_begin || (tx_commit && tx_active) || go_conflict || go_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active   <= 1'b0;
      abort_cause <= CAUSE_NONE;
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (clear_all) begin
        for (int s = 0; s < SETS; s++) vld[s] <= '0;
      end else if (go_alloc) begin
        vld[a_set][alloc_way] <= 1'b1;
      end
      if (tx_begin) begin
        tx_active   <= 1'b1;
        abort_cause <= CAUSE_NONE;
      end else if (tx_commit && tx_active) begin
        tx_active <= 1'b0;
      end else if (go_conflict) begin
        tx_active   <= 1'b0;
        abort_cause <= CAUSE_CONF;
      end else if (go_cap) begin
        tx_active   <= 1'b0;
        abort_cause <= CAUSE_CAP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go_alloc) begin
      tags[a_set][alloc_way] <= a_tag;
      rdb[a_set][alloc_way]  <= !acc_write;
      wrb[a_set][alloc_way]  <= acc_write;
    end else if (go_hit) begin
      rdb[a_set][hit_way] <= rdb[a_set][hit_way] || !acc_write;
      wrb[a_set][hit_way] <= wrb[a_set][hit_way] || acc_write;
    end
  end

  logic any_tracked;
  always_comb begin
    any_tracked = 1'b0;
    for (int s = 0; s < SETS; s++) any_tracked = any_tracked || (|vld[s]);
  end

  assert_begin_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_begin |=> (tx_active && abort_cause == CAUSE_NONE && !any_tracked));

  assert_overflow_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cycle && acc_valid && !snp_conflict && !(|a_hit) && !(|a_free))
      |=> (abort_cause == CAUSE_CAP && !tx_active));

  assert_snoop_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cycle && snp_valid && (|s_coll)) |=> (abort_cause == CAUSE_CONF && !tx_active));

  assert_commit_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_commit && tx_active && !tx_begin) |=> (!tx_active && abort_cause == CAUSE_NONE && !any_tracked));

  assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !any_tracked);

  assert_idle_cause_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !tx_begin) |=> $stable(abort_cause));

  assert_cause_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_cause != 2'd3);
endmodule

// File: tb/txn_rwset_tracker_tb.sv
`timescale 1ns/1ps
module txn_rwset_tracker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_begin = 0, tx_commit = 0, acc_valid = 0, acc_write = 0, snp_valid = 0, snp_write = 0;
  logic [31:0] acc_addr = '0, snp_addr = '0;
  logic tx_active, snp_conflict;
  logic [1:0] abort_cause;

  always #4 clk = ~clk;

  txn_rwset_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .tx_active(tx_active), .abort_cause(abort_cause), .snp_conflict(snp_conflict));

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  bit        m_act;
  bit [1:0]  m_cause;
  int        m_cnt [4];
  bit [22:0] m_tag [4][16];
  bit        m_r   [4][16];
  bit        m_w   [4][16];

  function automatic bit [31:0] mk(int s, int t, int o);
    return {23'(t), 2'(s), 7'(o)};
  endfunction

  function automatic int m_find(bit [31:0] a);
    int s = int'(a[8:7]);
    for (int i = 0; i < m_cnt[s]; i++) if (m_tag[s][i] == a[31:9]) return i;
    return -1;
  endfunction

  function automatic bit m_conf(bit v, bit wr, bit [31:0] a);
    int i;
    if (!v || !m_act) return 0;
    i = m_find(a);
    if (i < 0) return 0;
    return wr ? (m_r[int'(a[8:7])][i] || m_w[int'(a[8:7])][i]) : m_w[int'(a[8:7])][i];
  endfunction

  function automatic void m_clear();
    for (int s = 0; s < 4; s++) m_cnt[s] = 0;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(string req, bit b, bit c, bit av, bit aw, bit [31:0] aa,
                      bit sv, bit sw, bit [31:0] sa);
    bit conf;
    int s, i;
    tx_begin = b; tx_commit = c; acc_valid = av; acc_write = aw; acc_addr = aa;
    snp_valid = sv; snp_write = sw; snp_addr = sa;
    #1;
    conf = m_conf(sv, sw, sa);
    check({req, " R8 snp_conflict"}, int'(snp_conflict), int'(conf));
    @(posedge clk);
    if (b) begin m_clear(); m_act = 1; m_cause = 0; end
    else if (c && m_act) begin m_clear(); m_act = 0; end
    else if (m_act && conf) begin m_clear(); m_act = 0; m_cause = 2; end
    else if (m_act && av) begin
      s = int'(aa[8:7]);
      i = m_find(aa);
      if (i >= 0) begin
        if (aw) m_w[s][i] = 1; else m_r[s][i] = 1;
      end else if (m_cnt[s] == 16) begin
        m_clear(); m_act = 0; m_cause = 1;
      end else begin
        m_tag[s][m_cnt[s]] = aa[31:9]; m_r[s][m_cnt[s]] = !aw; m_w[s][m_cnt[s]] = aw;
        m_cnt[s]++;
      end
    end
    @(negedge clk);
    check({req, " tx_active"}, int'(tx_active), int'(m_act));
    check({req, " abort_cause"}, int'(abort_cause), int'(m_cause));
  endtask

  task automatic acc(string req, bit w, bit [31:0] a);
    step(req, 0, 0, 1, w, a, 0, 0, '0);
  endtask
  task automatic snp(string req, bit w, bit [31:0] a);
    step(req, 0, 0, 0, 0, '0, 1, w, a);
  endtask
  task automatic beg(string req);
    step(req, 1, 0, 0, 0, '0, 0, 0, '0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_act = 0; m_cause = 0; m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset tx_active", int'(tx_active), 0);
    check("R1 reset abort_cause", int'(abort_cause), 0);

    beg("R1 begin");
    // R2: one line, many offsets, one entry
    for (int k = 0; k < 20; k++) acc("R2 same line", k[0], mk(0, 5, k * 6));
    for (int t = 100; t < 115; t++) acc("R3 fill set0", 0, mk(0, t, 0));
    for (int t = 200; t < 216; t++) acc("R3 fill set1", 1, mk(1, t, 3));
    check("R3 sixteen per set held", int'(tx_active), 1);
    acc("R4 seventeenth line", 0, mk(0, 999, 0));
    check("R4 capacity code", int'(abort_cause), 1);
    // R10: ignored after abort
    acc("R10 access after abort", 1, mk(2, 1, 0));
    snp("R10 snoop after abort", 1, mk(0, 5, 0));
    check("R10 cause held", int'(abort_cause), 1);

    // R5: promotion of read lines uses no new ways
    beg("R5 begin");
    for (int t = 0; t < 16; t++) acc("R5 read fill", 0, mk(2, t, 0));
    for (int t = 0; t < 16; t++) acc("R5 store promote", 1, mk(2, t, 9));
    check("R5 no abort after promote", int'(abort_cause), 0);
    acc("R5 new store overflows", 1, mk(2, 77, 0));
    check("R5 capacity code", int'(abort_cause), 1);

    // R6, R7, R12
    beg("R7 begin");
    acc("R7 read A", 0, mk(1, 3, 0));
    snp("R7 remote read vs read", 0, mk(1, 3, 64));
    check("R7 read-read no conflict", int'(abort_cause), 0);
    snp("R12 other tag same set", 1, mk(1, 4, 0));
    check("R12 untracked no conflict", int'(tx_active), 1);
    snp("R6 remote write vs read", 1, mk(1, 3, 0));
    check("R6 conflict code", int'(abort_cause), 2);
    beg("R7 begin2");
    acc("R7 write B", 1, mk(3, 8, 0));
    snp("R7 remote read vs write", 0, mk(3, 8, 5));
    check("R7 conflict code", int'(abort_cause), 2);
    beg("R6 begin3");
    acc("R6 write C", 1, mk(0, 9, 0));
    snp("R6 remote write vs write", 1, mk(0, 9, 0));
    check("R6 write-write conflict", int'(abort_cause), 2);

    // R11 priorities
    beg("R11 begin");
    for (int t = 0; t < 16; t++) acc("R11 fill set3", 0, mk(3, t, 0));
    step("R11 conflict beats capacity", 0, 0, 1, 0, mk(3, 50, 0), 1, 1, mk(3, 2, 0));
    check("R11 conflict wins", int'(abort_cause), 2);
    beg("R11 begin2");
    acc("R11 read A", 0, mk(0, 1, 0));
    step("R11 commit beats conflict", 0, 1, 0, 0, '0, 1, 1, mk(0, 1, 0));
    check("R11 commit clean", int'(abort_cause), 0);

    // R9 commit frees all ways
    beg("R9 begin");
    for (int t = 0; t < 16; t++) acc("R9 fill", 1, mk(0, t, 0));
    step("R9 commit", 0, 1, 0, 0, '0, 0, 0, '0);
    check("R9 inactive", int'(tx_active), 0);
    beg("R9 begin again");
    for (int t = 30; t < 46; t++) acc("R9 refill", 0, mk(0, t, 0));
    check("R9 refill fits", int'(tx_active), 1);

    // random phase (model checks every cycle)
    for (int n = 0; n < 6000; n++) begin
      int r = $urandom % 100;
      bit b = 0, c = 0, av = 0, aw = 0, sv = 0, sw = 0;
      bit [31:0] aa = '0, sa = '0;
      if (!m_act) b = (r < 70);
      else if (r < 2) c = 1;
      else if (r < 3) b = 1;
      if (($urandom % 100) < 85) begin
        av = 1; aw = $urandom % 2; aa = mk($urandom % 4, $urandom % 20, $urandom % 128);
      end
      if (($urandom % 100) < 8) begin
        sv = 1; sw = $urandom % 2; sa = mk($urandom % 4, $urandom % 20, $urandom % 128);
      end
      step("R2 R3 R4 R5 R6 R7 random", b, c, av, aw, aa, sv, sw, sa);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule